// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block sits on the processor side of the external bus. It watches the maskable interrupt request line and, once a request has been qualified, waits for an instruction-boundary strobe. At that boundary it runs two back-to-back read cycles under a held bus lock. The cycle-definition outputs mark both reads as an interrupt acknowledge. The data returned in the first read is discarded. The interrupt vector is taken from the lowest byte lane of the second read.

The request line may come from an asynchronous source. It passes through a synchroniser, and it counts as a request only after it has been high for two consecutive synchronised samples. Each read holds its outputs until the bus reports ready. When the second read completes, the captured vector is presented with a one-clock valid pulse. That pulse is given only if the request is still asserted at the moment the sequence completes.

Top module: `intack_seq`

## Requirements
- R1: A sequence starts (bus_lock rises) only at a clock edge where instr_boundary is sampled high. While instr_boundary stays low, a pending request never starts a sequence.
- R2: bus_lock is high from the first clock of the first read to the last clock of the second read. The second read begins on the clock right after the first read completes, with no idle clock between the two.
- R3: During both reads, cyc_dc, cyc_mio and cyc_wr are all 0. In idle, all three are 1.
- R4: byte_en_n (active low) is 8'hEF during the first read and 8'hFE during the second read, where only lane 0 (bits 7:0) is enabled. In idle it is 8'hFF.
- R5: bus_addr (address bits 31:3) is all zeros during both reads.
- R6: vec_num is bus_data[7:0] as sampled at the edge where the second read completes. Data from the first read has no effect on it. Every value from 8'h00 to 8'hFF is carried unchanged.
- R7: Each read keeps its outputs unchanged until bus_ready is sampled high at a clock edge. Only that edge moves the sequencer on, either to the next read or to idle.
- R8: intr_req passes through a two-flop synchroniser and is qualified only after two consecutive high synchronised samples. A pulse lasting one clock starts nothing.
- R9: vec_valid is a single-clock pulse on the clock after the second read completes. It is given only if the synchronised intr_req is still high at that completion edge. If the request has dropped by then, the sequence still completes, but no vector is signalled.
- R10: No sequence starts while int_enable is low.
- R11: While rst_n is low at a clock edge (synchronous, active low), the sequencer returns to idle, bus_lock goes low, byte_en_n goes to 8'hFF and vec_valid goes low. This also applies in the middle of a sequence.
- R12: cyc_start pulses for exactly one clock at the first clock of each of the two reads. It is high at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| intr_req | input | 1 | Maskable interrupt request, may be asynchronous |
| instr_boundary | input | 1 | High in a clock where an instruction boundary is reached |
| int_enable | input | 1 | Interrupts accepted while high |
| bus_ready | input | 1 | Current bus cycle completes at this edge when high |
| bus_data | input | 64 | Read data bus |
| cyc_dc | output | 1 | Data/control cycle indicator, 0 during acknowledge |
| cyc_mio | output | 1 | Memory/IO cycle indicator, 0 during acknowledge |
| cyc_wr | output | 1 | Write/read cycle indicator, 0 during acknowledge |
| byte_en_n | output | 8 | Active-low byte lane enables |
| bus_addr | output | 29 | Address bits 31:3 |
| bus_lock | output | 1 | Bus lock held across both reads |
| cyc_start | output | 1 | First clock of each read |
| vec_valid | output | 1 | One-clock pulse when a vector is delivered |
| vec_num | output | 8 | Captured interrupt vector |

## Verification
The hardest case to reach from the ports is a sequence that is already running when the request drops. The drop has to pass through the synchroniser before the completion edge, so that the reads finish without any vector. To get there, the stimulus removes intr_req as the second read begins, then holds bus_ready low for two more clocks. This lets the falling level reach the synchronised sample in time. A second stimulus gives a two-clock pulse, which qualifies and starts a sequence but has already ended by completion. A one-clock pulse, a low interrupt enable and a missing boundary strobe are each held for long enough to show that no lock appears.

// File: rtl/intack_pkg.sv
// Shared types and constants for the interrupt acknowledge sequencer.
// Assumes an 8-lane data bus with active-low byte enables.
package intack_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD1  = 2'd1,
        ST_RD2  = 2'd2
    } ack_state_t;

    localparam logic [7:0] BE_FIRST = 8'hEF;
    localparam logic [7:0] BE_SECOND = 8'hFE;
    localparam logic [7:0] BE_NONE = 8'hFF;
endpackage

// File: rtl/intack_sync.sv
// Synchronises the request line and qualifies it by pulse width.
// Assumes SYNC_STAGES >= 1 and QUAL_CYCLES >= 2.
module intack_sync #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_raw,
    output logic req_sync,
    output logic req_qual
);
    localparam int HIST_W = QUAL_CYCLES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic [HIST_W-1:0]      hist;

    // Flop chain that brings the raw request into the clock domain.
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= req_raw;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign req_sync = chain[SYNC_STAGES-1];

    // History of earlier synchronised samples for the width qualifier.
    generate
        if (HIST_W == 1) begin : g_h1
            always_ff @(posedge clk) begin
                if (!rst_n) hist <= '0;
                else        hist <= req_sync;
            end
        end else begin : g_hn
            always_ff @(posedge clk) begin
                if (!rst_n) hist <= '0;
                else        hist <= {hist[HIST_W-2:0], req_sync};
            end
        end
    endgenerate

    // Qualified when the current and all remembered samples are high.
    assign req_qual = req_sync & (&hist);
endmodule

// File: rtl/intack_fsm.sv
// Runs the locked pair of acknowledge reads and decodes the bus outputs.
// Assumes bus_ready is synchronous to clk.
module intack_fsm
    import intack_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_qual,
    input  logic              instr_boundary,
    input  logic              int_enable,
    input  logic              bus_ready,
    output logic              done,
    output logic              cyc_dc,
    output logic              cyc_mio,
    output logic              cyc_wr,
    output logic [7:0]        byte_en_n,
    output logic [ADDR_W-1:3] bus_addr,
    output logic              bus_lock,
    output logic              cyc_start
);
    ack_state_t state, state_nx;
    logic       entered;

    // Next-state selection: accept at a boundary, advance on ready.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_qual && int_enable && instr_boundary) state_nx = ST_RD1;
            ST_RD1:  if (bus_ready) state_nx = ST_RD2;
            ST_RD2:  if (bus_ready) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Marks the first clock of each read.
    always_ff @(posedge clk) begin
        if (!rst_n) entered <= 1'b0;
        else        entered <= (state_nx != state) && (state_nx != ST_IDLE);
    end

    // Bus output decode from the current state.
    always_comb begin
        bus_lock  = (state != ST_IDLE);
        cyc_dc    = !bus_lock;
        cyc_mio   = !bus_lock;
        cyc_wr    = !bus_lock;
        bus_addr  = '0;
        unique case (state)
            ST_RD1:  byte_en_n = BE_FIRST;
            ST_RD2:  byte_en_n = BE_SECOND;
            default: byte_en_n = BE_NONE;
        endcase
    end

    assign cyc_start = entered;
    assign done      = (state == ST_RD2) && bus_ready;
endmodule

// File: rtl/intack_vec_cap.sv
// Captures the vector byte at completion and pulses valid if still requested.
// Assumes done is a single-clock completion strobe.
module intack_vec_cap #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic             req_live,
    input  logic [VEC_W-1:0] data_lo,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_num
);
    // Vector register, loaded only when the second read completes.
    always_ff @(posedge clk) begin
        if (!rst_n)    vec_num <= '0;
        else if (done) vec_num <= data_lo;
    end

    // Valid pulse, gated by the request still being present.
    always_ff @(posedge clk) begin
        if (!rst_n) vec_valid <= 1'b0;
        else        vec_valid <= done && req_live;
    end
endmodule

// File: rtl/intack_seq.sv
// Top of the interrupt acknowledge sequencer: synchroniser, sequencer, capture.
// Assumes the vector arrives on the lowest byte lane of the data bus.
module intack_seq #(
    parameter int DATA_W      = 64,
    parameter int ADDR_W      = 32,
    parameter int VEC_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              intr_req,
    input  logic              instr_boundary,
    input  logic              int_enable,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_data,
    output logic              cyc_dc,
    output logic              cyc_mio,
    output logic              cyc_wr,
    output logic [7:0]        byte_en_n,
    output logic [ADDR_W-1:3] bus_addr,
    output logic              bus_lock,
    output logic              cyc_start,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_num
);
    logic req_sync, req_qual, done;
    logic unused_hi;

    assign unused_hi = ^bus_data[DATA_W-1:VEC_W];

    intack_sync #(.SYNC_STAGES(SYNC_STAGES), .QUAL_CYCLES(QUAL_CYCLES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_raw  (intr_req),
        .req_sync (req_sync),
        .req_qual (req_qual)
    );

    intack_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_qual       (req_qual),
        .instr_boundary (instr_boundary),
        .int_enable     (int_enable),
        .bus_ready      (bus_ready),
        .done           (done),
        .cyc_dc         (cyc_dc),
        .cyc_mio        (cyc_mio),
        .cyc_wr         (cyc_wr),
        .byte_en_n      (byte_en_n),
        .bus_addr       (bus_addr),
        .bus_lock       (bus_lock),
        .cyc_start      (cyc_start)
    );

    intack_vec_cap #(.VEC_W(VEC_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .req_live  (req_sync),
        .data_lo   (bus_data[VEC_W-1:0]),
        .vec_valid (vec_valid),
        .vec_num   (vec_num)
    );
endmodule

// File: rtl/intack_seq_chk.sv
// Port-level protocol checker for the acknowledge sequencer, bound to the top.
// Assumes the default byte lane layout.
module intack_seq_chk #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int VEC_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_boundary,
    input logic              int_enable,
    input logic              bus_ready,
    input logic [DATA_W-1:0] bus_data,
    input logic              cyc_dc,
    input logic              cyc_mio,
    input logic              cyc_wr,
    input logic [7:0]        byte_en_n,
    input logic [ADDR_W-1:3] bus_addr,
    input logic              bus_lock,
    input logic              cyc_start,
    input logic              vec_valid,
    input logic [VEC_W-1:0]  vec_num
);
    // R1 R10
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_lock) |-> $past(instr_boundary && int_enable));

    // R2
    pair_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock && byte_en_n == 8'hEF && bus_ready) |=> (bus_lock && byte_en_n == 8'hFE));

    // R3 R5
    ack_def_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lock |-> (!cyc_dc && !cyc_mio && !cyc_wr && bus_addr == '0));

    // R4
    first_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_lock) |-> byte_en_n == 8'hEF);

    // R4
    idle_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_lock |-> (byte_en_n == 8'hFF && cyc_dc && cyc_mio && cyc_wr));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock && !bus_ready) |=> (bus_lock && $stable(byte_en_n)));

    // R9
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(bus_lock && byte_en_n == 8'hFE && bus_ready));

    // R6
    vec_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> vec_num == $past(bus_data[VEC_W-1:0]));

    // R12
    start_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_lock) |-> cyc_start);

    // R12
    start_in_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> bus_lock);
endmodule

bind intack_seq intack_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .instr_boundary (instr_boundary),
    .int_enable     (int_enable),
    .bus_ready      (bus_ready),
    .bus_data       (bus_data),
    .cyc_dc         (cyc_dc),
    .cyc_mio        (cyc_mio),
    .cyc_wr         (cyc_wr),
    .byte_en_n      (byte_en_n),
    .bus_addr       (bus_addr),
    .bus_lock       (bus_lock),
    .cyc_start      (cyc_start),
    .vec_valid      (vec_valid),
    .vec_num        (vec_num)
);

// File: tb/intack_seq_bench.sv
// Scoreboard bench: the driver queues expected vectors, the monitor pops them on vec_valid.
module intack_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        intr_req = 1'b0;
    logic        instr_boundary = 1'b0;
    logic        int_enable = 1'b0;
    logic        bus_ready = 1'b0;
    logic [63:0] bus_data = '0;
    logic        cyc_dc, cyc_mio, cyc_wr, bus_lock, cyc_start, vec_valid;
    logic [7:0]  byte_en_n, vec_num;
    logic [31:3] bus_addr;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [7:0] exp_q[$];
    logic prev_valid = 1'b0;

    always #5 clk = ~clk;

    intack_seq u_intack_seq (
        .clk(clk), .rst_n(rst_n), .intr_req(intr_req), .instr_boundary(instr_boundary),
        .int_enable(int_enable), .bus_ready(bus_ready), .bus_data(bus_data),
        .cyc_dc(cyc_dc), .cyc_mio(cyc_mio), .cyc_wr(cyc_wr), .byte_en_n(byte_en_n),
        .bus_addr(bus_addr), .bus_lock(bus_lock), .cyc_start(cyc_start),
        .vec_valid(vec_valid), .vec_num(vec_num)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares every delivered vector with the queue head (R6, R9).
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected vec_valid", {56'd0, vec_num}, 64'd0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(vec_num == e, "R6 vector value", {56'd0, vec_num}, {56'd0, e});
            end
            if (prev_valid) chk(1'b0, "R9 pulse longer than one clock", 64'd1, 64'd0);
        end
        prev_valid = vec_valid;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic idle_wait(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!bus_lock, tag, {63'd0, bus_lock}, 64'd0);
        end
    endtask

    // Driver: one full acknowledge, queueing the vector when it should be delivered.
    task automatic ack_run(input logic [7:0] vec, input logic [63:0] junk, input int w1,
                           input int w2, input bit keep);
        int n = 0;
        intr_req = 1'b1; int_enable = 1'b1; instr_boundary = 1'b1; bus_ready = 1'b0;
        bus_data = junk;
        while (!bus_lock && n < 20) begin @(negedge clk); n++; end
        chk(bus_lock, "R1 sequence start", {63'd0, bus_lock}, 64'd1);
        chk(cyc_start, "R12 start mark first read", {63'd0, cyc_start}, 64'd1);
        chk(byte_en_n == 8'hEF, "R4 first read enables", {56'd0, byte_en_n}, 64'hEF);
        chk({cyc_dc, cyc_mio, cyc_wr} == 3'b000, "R3 acknowledge decode", {61'd0, cyc_dc, cyc_mio, cyc_wr}, 64'd0);
        chk(bus_addr == '0, "R5 zero address", {35'd0, bus_addr}, 64'd0);
        instr_boundary = 1'b0;
        for (int i = 0; i < w1; i++) begin
            @(negedge clk);
            chk(bus_lock && byte_en_n == 8'hEF && !cyc_start, "R7 first read held", {56'd0, byte_en_n}, 64'hEF);
        end
        bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
        chk(bus_lock && byte_en_n == 8'hFE, "R2 second read follows", {56'd0, byte_en_n}, 64'hFE);
        chk(cyc_start, "R12 start mark second read", {63'd0, cyc_start}, 64'd1);
        chk({cyc_dc, cyc_mio, cyc_wr} == 3'b000, "R3 acknowledge decode second", {61'd0, cyc_dc, cyc_mio, cyc_wr}, 64'd0);
        bus_data = {~junk[63:8], vec};
        if (keep) exp_q.push_back(vec);
        else      intr_req = 1'b0;
        for (int i = 0; i < w2; i++) begin
            @(negedge clk);
            chk(bus_lock && byte_en_n == 8'hFE && !cyc_start, "R7 second read held", {56'd0, byte_en_n}, 64'hFE);
        end
        bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
        intr_req = 1'b0;
        chk(!bus_lock && byte_en_n == 8'hFF, "R2 lock released after pair", {56'd0, byte_en_n}, 64'hFF);
        chk({cyc_dc, cyc_mio, cyc_wr} == 3'b111, "R3 idle decode", {61'd0, cyc_dc, cyc_mio, cyc_wr}, 64'd7);
        if (keep) chk(vec_valid, "R9 vector delivered", {63'd0, vec_valid}, 64'd1);
        else      chk(!vec_valid, "R9 dropped request gives no vector", {63'd0, vec_valid}, 64'd0);
        idle_wait(4, "R9 no restart after completion");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!bus_lock && byte_en_n == 8'hFF && !vec_valid && !cyc_start, "R11 reset state",
            {55'd0, bus_lock, byte_en_n}, 64'h0FF);
        rst_n = 1'b1;
        @(negedge clk);

        // Main function with several vectors and ready timings.
        ack_run(8'hA5, 64'h1111_2222_3333_445A, 0, 0, 1'b1);
        ack_run(8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 3, 1, 1'b1);
        ack_run(8'hFF, 64'h0, 1, 4, 1'b1);
        ack_run(8'h3C, 64'hDEAD_BEEF_0BAD_F0C3, 2, 2, 1'b1);

        // R9: request removed during the second read; sequence completes silently.
        ack_run(8'h77, 64'h55, 1, 2, 1'b0);

        // R1: request present, no boundary.
        intr_req = 1'b1; int_enable = 1'b1; instr_boundary = 1'b0;
        idle_wait(10, "R1 no start without boundary");
        intr_req = 1'b0;
        idle_wait(4, "R1 settle");

        // R10: boundary and request present, interrupts disabled.
        intr_req = 1'b1; int_enable = 1'b0; instr_boundary = 1'b1;
        idle_wait(10, "R10 no start while disabled");
        intr_req = 1'b0;
        idle_wait(4, "R10 settle");

        // R8: one-clock pulse must be ignored.
        int_enable = 1'b1; instr_boundary = 1'b1;
        intr_req = 1'b1;
        @(negedge clk);
        intr_req = 1'b0;
        idle_wait(10, "R8 one-clock pulse ignored");

        // R8 R9: two-clock pulse starts a sequence but yields no vector.
        bus_ready = 1'b1;
        intr_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        intr_req = 1'b0;
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (bus_lock) seen = 1'b1;
            end
            chk(seen, "R8 two-clock pulse accepted", {63'd0, seen}, 64'd1);
        end
        chk(!bus_lock, "R9 short request sequence completed", {63'd0, bus_lock}, 64'd0);
        bus_ready = 1'b0; instr_boundary = 1'b0;
        idle_wait(4, "R8 settle");

        // R11: reset in the middle of the first read.
        intr_req = 1'b1; instr_boundary = 1'b1;
        begin
            int n = 0;
            while (!bus_lock && n < 20) begin @(negedge clk); n++; end
        end
        chk(bus_lock, "R11 sequence running before reset", {63'd0, bus_lock}, 64'd1);
        intr_req = 1'b0; instr_boundary = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(!bus_lock && byte_en_n == 8'hFF && !vec_valid, "R11 reset mid-sequence",
            {55'd0, bus_lock, byte_en_n}, 64'h0FF);
        rst_n = 1'b1;
        idle_wait(5, "R11 stays idle after reset");

        // Final sequence after reset still works.
        ack_run(8'h81, 64'h0123_4567_89AB_CD18, 1, 1, 1'b1);

        chk(exp_q.size() == 0, "R9 all expected vectors delivered", exp_q.size(), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule